// File: doc/BRIEF.md
# Fractional Bit-Clock and PCM Frame Generator

This block derives a serial audio bit clock from a reference clock by dividing it by a divisor with an integer part and a fractional part. The fractional part is handled by first-order noise shaping: a 12-bit accumulator gathers the fraction once per output period, and each overflow lengthens that period by one reference cycle. Over many periods the average divide ratio then equals integer plus fraction/4096. For example, integer 13 with fraction 2479 turns a 19.2 MHz internal oscillator into the bit clock of a 44.1 kHz stereo stream with 32-bit frames.

The bit clock drives a frame timer. It produces a frame sync that is high for the first 16 of every 32 bit periods. It also shifts out a 32-bit sample, most significant bit first, with one bit per bit period. Two 32-bit configuration registers control the block: a control word and a divisor word. A write to either register is accepted only when its top byte carries a fixed key. The divisor can be changed only while the generator is stopped, so a running output clock never sees a partly updated ratio.

Top module: `pcm_frac_clkgen`

## Requirements
- R1: A register write whose bits 31:24 differ from 0x5A leaves both registers unchanged, as read back.
- R2: The control register holds source select in bits 3:0, enable in bit 4 and shaping mode in bits 10:9, and reads back with those fields. Bit 7 reads 1 exactly when enable is 1 and source is 1 (the internal oscillator). Bit 7 and all other bits cannot be written.
- R3: The divisor register holds the integer part in bits 23:12 and the fraction in bits 11:0, with bits 31:24 reading as zero. A keyed write to it is ignored while enable is 1.
- R4: Unless enable is 1 and source is 1, bit clock, frame sync and serial data stay low.
- R5: In shaping mode 1, each bit period lasts the integer part in reference cycles, plus one when adding the fraction to a 12-bit accumulator overflows. The accumulator starts at zero when the generator starts, and the first addition belongs to the first period.
- R6: In any shaping mode other than 1, every bit period lasts exactly the integer part and the fraction is unused.
- R7: The bit clock rises at the start of each period and stays high for floor(N/2) reference cycles, where N is the integer part. An integer part below 2 acts as 2.
- R8: A frame spans 32 bit periods. Frame sync is high during the first 16 of them and rises on the same edge as the bit clock.
- R9: Serial data is captured from `sample_in` on the bit-clock rise that starts a frame. It is sent most significant bit first, and each later bit appears on the next bit-clock rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 divisor |
| wr_data | input | 32 | Write value, key in bits 31:24 |
| rd_sel | input | 1 | Read target: 0 control, 1 divisor |
| rd_data | output | 32 | Selected register value |
| sample_in | input | 32 | Sample to send in the next frame |
| bclk | output | 1 | Derived bit clock |
| fsync | output | 1 | Frame sync |
| sdout | output | 1 | Serial data out |

## Verification
A corrupted fractional accumulator shows at the ports as a single period that is one reference cycle too long or too short, within one bit period of the error. For this reason the bench measures every period against its own running accumulator, instead of averaging over a frame. A wrong frame counter shows as a misplaced frame sync edge or a shifted data bit within one frame of 32 bit periods. A key or lock fault shows up at once in the register read-back, or as an output clock that starts when it should stay silent.

// File: rtl/pcm_frac_clkgen.sv
module pcm_frac_clkgen #(
  parameter int          INT_W      = 12,
  parameter int          FRAC_W     = 12,
  parameter int          FRAME_BITS = 32,
  parameter int          SYNC_BITS  = 16,
  parameter logic [7:0]  KEY        = 8'h5A,
  parameter logic [3:0]  SRC_OSC    = 4'd1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_sel,
  input  logic [31:0]           wr_data,
  input  logic                  rd_sel,
  output logic [31:0]           rd_data,
  input  logic [FRAME_BITS-1:0] sample_in,
  output logic                  bclk,
  output logic                  fsync,
  output logic                  sdout
);
  localparam int CNT_W = INT_W + 1;
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [31:0] CTRL_MASK = 32'h0000_061F;
  localparam logic [31:0] DIV_MASK  = (32'd1 << (INT_W + FRAC_W)) - 32'd1;

  logic [31:0] ctrl_q, div_q;
  wire key_ok = (wr_data[31:24] == KEY);
  wire running = ctrl_q[4] && (ctrl_q[3:0] == SRC_OSC);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else if (wr_en && key_ok) begin
      if (!wr_sel)        ctrl_q <= wr_data & CTRL_MASK;
      else if (!ctrl_q[4]) div_q <= wr_data & DIV_MASK;
    end

  assign rd_data = rd_sel ? div_q : (ctrl_q | {24'd0, running, 7'd0});

  wire [INT_W-1:0]  int_raw  = div_q[FRAC_W +: INT_W];
  wire [INT_W-1:0]  int_eff  = (int_raw < INT_W'(2)) ? INT_W'(2) : int_raw;
  wire [FRAC_W-1:0] frac_eff = (ctrl_q[10:9] == 2'd1) ? div_q[FRAC_W-1:0] : '0;
  wire [INT_W-1:0]  hi_len   = int_eff >> 1;

  logic              active_q, bclk_q, fs_q;
  logic [CNT_W-1:0]  cnt_q, last_q;
  logic [FRAC_W-1:0] acc_q;
  logic [BIT_W-1:0]  bit_q;
  logic [FRAME_BITS-1:0] sh_q;

  wire [FRAC_W:0] acc_sum = {1'b0, acc_q} + {1'b0, frac_eff};
  wire start = running && (!active_q || cnt_q == last_q);
  wire [BIT_W-1:0] bit_n = !active_q ? '0 :
                           (bit_q == BIT_W'(FRAME_BITS - 1)) ? '0 : bit_q + 1'b1;

  always_ff @(posedge clk)
    if (!rst_n || !running) begin
      active_q <= 1'b0;
      bclk_q   <= 1'b0;
      fs_q     <= 1'b0;
      cnt_q    <= '0;
      last_q   <= '0;
      acc_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      last_q   <= CNT_W'(int_eff) - CNT_W'(1) + CNT_W'(acc_sum[FRAC_W]);
      acc_q    <= acc_sum[FRAC_W-1:0];
      bclk_q   <= 1'b1;
      bit_q    <= bit_n;
      fs_q     <= (bit_n < BIT_W'(SYNC_BITS));
      sh_q     <= (bit_n == '0) ? sample_in : (sh_q << 1);
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      bclk_q <= (cnt_q + 1'b1) < CNT_W'(hi_len);
    end

  assign bclk  = bclk_q;
  assign fsync = fs_q;
  assign sdout = sh_q[FRAME_BITS-1];

  AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !key_ok) |=> ($stable(ctrl_q) && $stable(div_q))); // R1
  AST_DIV_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && ctrl_q[4]) |=> $stable(div_q)); // R3
  AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (!bclk && !fsync && !sdout)); // R4
  AST_SYNC_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync) |-> $rose(bclk)); // R8
  AST_SD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !$rose(bclk)) |-> $stable(sdout)); // R9
endmodule

// File: tb/test_pcm_frac_clkgen.sv
module test_pcm_frac_clkgen;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SMP = 32'hA5C3_0F96;

  logic clk = 0, rst_n = 0, wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [31:0] wr_data = '0, rd_data, sample_in = SMP;
  logic bclk, fsync, sdout;
  int n_run = 0, n_fail = 0;

  pcm_frac_clkgen i_pcm_frac_clkgen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .sample_in(sample_in),
    .bclk(bclk), .fsync(fsync), .sdout(sdout));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_check(input string req, input logic sel, input logic [31:0] exp);
    rd_sel = sel; #1; check(req, rd_data, exp);
  endtask

  task automatic quiet(input string req, input int cycles);
    logic seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (bclk || fsync || sdout) seen = 1;
    end
    check(req, {31'd0, seen}, 32'd0);
  endtask

  task automatic observe(input string req, input int n, input int iv, input int fr);
    int ie = (iv < 2) ? 2 : iv;
    int acc = 0, rises = 0, last_rise = 0, hi = 0, cyc = 0, exp_len = 0, b;
    logic prev = 0;
    while (rises < n + 1 && cyc < 20000) begin
      @(negedge clk); cyc++;
      if (bclk && !prev) begin
        if (rises > 0) begin
          check({req, " R5/R6 period"}, cyc - last_rise, exp_len);
          check({req, " R7 high time"}, hi, ie / 2);
        end
        acc = acc + fr;
        exp_len = ie + ((acc >= 4096) ? 1 : 0);
        acc = acc % 4096;
        b = rises % 32;
        check({req, " R8 fsync"}, {31'd0, fsync}, {31'd0, (b < 16)});
        check({req, " R9 sdout"}, {31'd0, sdout}, {31'd0, SMP[31-b]});
        last_rise = cyc; hi = 0; rises++;
      end
      if (bclk) hi++;
      prev = bclk;
    end
    check({req, " rises seen"}, rises, n + 1);
  endtask

  task automatic t_reset;
    rd_check("R2 ctrl reset", 0, 32'h0);
    rd_check("R3 div reset", 1, 32'h0);
    quiet("R4 reset quiet", 20);
  endtask

  task automatic t_key;
    wr(0, 32'h0000_0211);
    rd_check("R1 ctrl no key", 0, 32'h0);
    wr(1, 32'hA500_D9AF);
    rd_check("R1 div no key", 1, 32'h0);
    quiet("R1/R4 stays quiet", 40);
  endtask

  task automatic t_fields;
    wr(1, 32'h5A00_D9AF);
    rd_check("R3 div fields", 1, 32'h0000_D9AF);
    wr(0, 32'h5AFF_FFF2);
    rd_check("R2 ctrl mask, busy off", 0, 32'h0000_0612);
    quiet("R4 source 2 quiet", 40);
    wr(0, 32'h5A00_0201);
    rd_check("R2 enable off busy", 0, 32'h0000_0201);
    quiet("R4 enable low quiet", 40);
  endtask

  task automatic t_frac;
    wr(0, 32'h5A00_0211);
    rd_check("R2 busy on", 0, 32'h0000_0291);
    observe("R5 int13 frac2479", 70, 13, 2479);
    wr(1, 32'h5A00_5000);
    rd_check("R3 div locked", 1, 32'h0000_D9AF);
    wr(0, 32'h5A00_0201);
    quiet("R4 stopped quiet", 30);
  endtask

  task automatic t_int_only;
    wr(1, 32'h5A00_59AF);
    wr(0, 32'h5A00_0011);
    observe("R6 mode0 int5", 40, 5, 0);
    wr(0, 32'h5A00_0000);
    wr(0, 32'h5A00_0611);
    observe("R6 mode3 int5", 10, 5, 0);
    wr(0, 32'h5A00_0000);
  endtask

  task automatic t_min;
    wr(1, 32'h5A00_1800);
    wr(0, 32'h5A00_0211);
    observe("R7 int1 as 2", 34, 1, 2048);
    wr(0, 32'h5A00_0000);
    quiet("R4 final quiet", 10);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_key();
    t_fields();
    t_frac();
    t_int_only();
    t_min();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule